// File: doc/BRIEF.md
# Analog Memory Readout Scanner

This controller runs the read pass of a bank of serial analog storage chips once a measurement window has closed. Each storage chip belongs to one channel and holds one sampled level per trigger. The scanner visits every channel of every configured module in order. For each channel it reads exactly as many cells as triggers were recorded in the window. It then clocks the chip's read pointer past its end, so the chip lets go of the shared output line.

For every cell it produces a pair of read-clock pulses and a sample/convert request on the first pulse. It then waits for the converter to report completion. After that it holds for a programmable settling time so the output line can discharge before the next cell. The transfer side paces the pass: every cell waits for the host-ready level. The channel and module address fields, together with the cell index, tag each converted value.

Top module: `analog_mem_scanner`

## Requirements
- R1: While reset is held and just after it, every strobe is low, `scan_done` is low, and `chan_addr`, `mod_addr` and `cell_idx` are zero.
- R2: A scan starts on a clock edge only when `meas_window` is low, `host_ready` is high and `data_present` is high, all at that edge. Until then every strobe stays low.
- R3: Each channel opens with exactly one cycle in which `start_out` and `clock_out` are both high. In that cycle `cell_idx` is 0 and the address shows the channel.
- R4: Each cell read waits for `host_ready`. It then drives `clock_out` high with `sample` and `convert` for one cycle, then one low cycle, then a second one-cycle `clock_out` pulse, and then waits for `conv_ready`.
- R5: After `conv_ready` is seen, all strobes stay low for DISCHARGE_CYC cycles. Only then does the next cell read (with `cell_idx` one higher) or the end of the channel follow.
- R6: The number of cells read per channel is `trig_count`, latched when the scan starts and limited to the range 1..2^CELL_W. A value of 0 reads one cell, a larger value reads 2^CELL_W cells, and later changes of the input have no effect.
- R7: After the last read of a channel, 2*(2^CELL_W - count) further `clock_out` pulses follow, each one high cycle then one low cycle, with the other strobes low. When the count equals 2^CELL_W, no such pulses follow.
- R8: `chan_addr` (4 bits) runs from 0 to 15 within a module. After channel 15, `mod_addr` (5 bits) steps up by one and `chan_addr` returns to 0. The address changes only in a cycle where `start_out` is high.
- R9: After the last channel of module NUM_MODULES-1, `scan_done` rises and stays high with the address held until `meas_window` is seen high. The block then goes idle.
- R10: `sample` and `convert` are never high without `clock_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_window | input | 1 | High while the measurement window is open |
| host_ready | input | 1 | Transfer side ready for another value |
| data_present | input | 1 | At least one trigger occurred in the window |
| trig_count | input | CELL_W+1 | Number of triggers recorded in the window |
| conv_ready | input | 1 | Converter finished the current conversion |
| start_out | output | 1 | Read-pointer start strobe |
| clock_out | output | 1 | Read-pointer clock strobe |
| sample | output | 1 | Sample-and-hold request |
| convert | output | 1 | Conversion start request |
| chan_addr | output | CH_W | Channel within module |
| mod_addr | output | MOD_W | Module number |
| cell_idx | output | CELL_W | Cell being read in the channel |
| scan_done | output | 1 | Scan complete |

## Verification
The pass is tried with a count of three that is changed mid-scan, a full count that needs no flush pulses, a zero count that must read one cell, and an oversized count that must saturate. This separates the limiting and latching of the count from the flush length. Runs with ready levels held high are compared against runs where both `host_ready` and `conv_ready` stall at pseudo-random cycles, which exposes any step that does not wait. Before the first scan, each start condition is withheld in turn to show that no single missing level is ignored.

// File: rtl/analog_mem_scanner.sv
module analog_mem_scanner #(
  parameter int NUM_MODULES   = 22,
  parameter int CH_W          = 4,
  parameter int MOD_W         = 5,
  parameter int CELL_W        = 5,
  parameter int DISCHARGE_CYC = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_window,
  input  logic              host_ready,
  input  logic              data_present,
  input  logic [CELL_W:0]   trig_count,
  input  logic              conv_ready,
  output logic              start_out,
  output logic              clock_out,
  output logic              sample,
  output logic              convert,
  output logic [CH_W-1:0]   chan_addr,
  output logic [MOD_W-1:0]  mod_addr,
  output logic [CELL_W-1:0] cell_idx,
  output logic              scan_done
);

  localparam int TRIG_W = CELL_W + 1;
  localparam int FL_W   = CELL_W + 3;
  localparam int DIS_W  = $clog2(DISCHARGE_CYC + 1);
  localparam logic [TRIG_W-1:0] DEPTH_V = TRIG_W'(1) << CELL_W;
  localparam logic [MOD_W-1:0]  LAST_MOD = MOD_W'(NUM_MODULES - 1);
  localparam logic [DIS_W-1:0]  DIS_END  = DIS_W'(DISCHARGE_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CH, S_WAIT, S_CA, S_GAP, S_CB, S_CONV, S_DIS, S_FH, S_FL, S_DONE
  } state_t;

  state_t              st;
  logic [TRIG_W-1:0]   trig_q;
  logic [CH_W-1:0]     chan_q;
  logic [MOD_W-1:0]    mod_q;
  logic [CELL_W-1:0]   cell_q;
  logic [DIS_W-1:0]    dis_q;
  logic [FL_W-1:0]     fl_q;

  logic go, last_cell, last_ch;
  logic [TRIG_W-1:0] trig_lim;
  logic [FL_W-1:0]   fl_need;

  assign go        = !meas_window && host_ready && data_present;
  assign trig_lim  = (trig_count == '0) ? TRIG_W'(1) :
                     (trig_count > DEPTH_V) ? DEPTH_V : trig_count;
  assign last_cell = ({1'b0, cell_q} + TRIG_W'(1)) == trig_q;
  assign last_ch   = (chan_q == '1) && (mod_q == LAST_MOD);
  assign fl_need   = {({1'b0, DEPTH_V} - {1'b0, trig_q}), 1'b0};

  assign start_out = (st == S_CH);
  assign clock_out = (st == S_CH) || (st == S_CA) || (st == S_CB) || (st == S_FH);
  assign sample    = (st == S_CA);
  assign convert   = (st == S_CA);
  assign scan_done = (st == S_DONE);
  assign chan_addr = chan_q;
  assign mod_addr  = mod_q;
  assign cell_idx  = cell_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      trig_q <= TRIG_W'(1);
      chan_q <= '0;
      mod_q  <= '0;
      cell_q <= '0;
      dis_q  <= '0;
      fl_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          trig_q <= trig_lim;
          chan_q <= '0;
          mod_q  <= '0;
          cell_q <= '0;
          st     <= S_CH;
        end
        S_CH:   st <= S_WAIT;
        S_WAIT: if (host_ready) st <= S_CA;
        S_CA:   st <= S_GAP;
        S_GAP:  st <= S_CB;
        S_CB:   st <= S_CONV;
        S_CONV: if (conv_ready) begin
          dis_q <= '0;
          st    <= S_DIS;
        end
        S_DIS: begin
          if (dis_q != DIS_END) begin
            dis_q <= dis_q + DIS_W'(1);
          end else if (!last_cell) begin
            cell_q <= cell_q + CELL_W'(1);
            st     <= S_WAIT;
          end else if (fl_need != '0) begin
            fl_q <= fl_need;
            st   <= S_FH;
          end else if (last_ch) begin
            st <= S_DONE;
          end else begin
            chan_q <= chan_q + CH_W'(1);
            if (chan_q == '1) mod_q <= mod_q + MOD_W'(1);
            cell_q <= '0;
            st     <= S_CH;
          end
        end
        S_FH: st <= S_FL;
        S_FL: begin
          if (fl_q != FL_W'(1)) begin
            fl_q <= fl_q - FL_W'(1);
            st   <= S_FH;
          end else if (last_ch) begin
            st <= S_DONE;
          end else begin
            chan_q <= chan_q + CH_W'(1);
            if (chan_q == '1) mod_q <= mod_q + MOD_W'(1);
            cell_q <= '0;
            st     <= S_CH;
          end
        end
        S_DONE: if (meas_window) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_sample_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (sample || convert) |-> clock_out);
  a_r3_start_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
    start_out |-> clock_out);
  a_r4_clock_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    clock_out |=> !clock_out);
  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !meas_window) |=> scan_done);
  a_r8_addr_moves_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mod_addr, chan_addr}) |-> start_out);
  a_r6_cell_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cell_idx} < trig_q));

endmodule

// File: tb/analog_mem_scanner_test.sv
module analog_mem_scanner_test;
  localparam int NM = 2, CH_W = 4, MOD_W = 5, CELL_W = 3, DIS = 3;
  localparam int DEPTH = 1 << CELL_W;

  logic clk = 0, rst_n = 0;
  logic meas_window = 1, host_ready = 0, data_present = 0, conv_ready = 0;
  logic [CELL_W:0] trig_count = 0;
  logic start_out, clock_out, sample, convert, scan_done;
  logic [CH_W-1:0] chan_addr;
  logic [MOD_W-1:0] mod_addr;
  logic [CELL_W-1:0] cell_idx;

  analog_mem_scanner #(.NUM_MODULES(NM), .CH_W(CH_W), .MOD_W(MOD_W),
    .CELL_W(CELL_W), .DISCHARGE_CYC(DIS)) uut (
    .clk(clk), .rst_n(rst_n), .meas_window(meas_window), .host_ready(host_ready),
    .data_present(data_present), .trig_count(trig_count), .conv_ready(conv_ready),
    .start_out(start_out), .clock_out(clock_out), .sample(sample), .convert(convert),
    .chan_addr(chan_addr), .mod_addr(mod_addr), .cell_idx(cell_idx), .scan_done(scan_done));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit model_on = 0, rand_mode = 0, host_lvl = 0, finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic e_start = 0, e_clk = 0, e_smp = 0, e_done = 0;
  logic [CH_W-1:0] e_chan = 0;
  logic [MOD_W-1:0] e_mod = 0;
  logic [CELL_W-1:0] e_cell = 0;
  string tag = "R1";

  task automatic set_o(input logic s, input logic c, input logic sm, input logic d, input string t);
    e_start = s; e_clk = c; e_smp = sm; e_done = d; tag = t;
  endtask

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    host_ready <= rand_mode ? (lfsr[1] | lfsr[4]) : host_lvl;
    conv_ready <= rand_mode ? (lfsr[2] & lfsr[6]) : 1'b1;
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(tag, {start_out, clock_out, sample, convert, scan_done},
          {e_start, e_clk, e_smp, e_smp, e_done}, "strobes{start,clk,smp,cnv,done}");
      chk("R8", {mod_addr, chan_addr}, {e_mod, e_chan}, "address{mod,chan}");
      chk("R6", cell_idx, e_cell, "cell_idx");
    end
  end

  initial begin
    int tq;
    wait (rst_n === 1'b1);
    model_on = 1;
    forever begin
      set_o(0, 0, 0, 0, "R2");
      forever begin
        @(posedge clk);
        if (!meas_window && host_ready && data_present) break;
      end
      tq = (trig_count == 0) ? 1 : ((trig_count > DEPTH) ? DEPTH : int'(trig_count));
      for (int m = 0; m < NM; m++) begin
        for (int c = 0; c < (1 << CH_W); c++) begin
          e_mod = MOD_W'(m); e_chan = CH_W'(c); e_cell = 0;
          set_o(1, 1, 0, 0, "R3"); @(posedge clk);
          for (int k = 0; k < tq; k++) begin
            e_cell = CELL_W'(k);
            set_o(0, 0, 0, 0, "R4");
            forever begin @(posedge clk); if (host_ready) break; end
            set_o(0, 1, 1, 0, "R4"); @(posedge clk);
            set_o(0, 0, 0, 0, "R4"); @(posedge clk);
            set_o(0, 1, 0, 0, "R4"); @(posedge clk);
            set_o(0, 0, 0, 0, "R4");
            forever begin @(posedge clk); if (conv_ready) break; end
            set_o(0, 0, 0, 0, "R5");
            repeat (DIS) @(posedge clk);
          end
          for (int p = 0; p < 2 * (DEPTH - tq); p++) begin
            set_o(0, 1, 0, 0, "R7"); @(posedge clk);
            set_o(0, 0, 0, 0, "R7"); @(posedge clk);
          end
        end
      end
      set_o(0, 0, 0, 1, "R9");
      forever begin @(posedge clk); if (meas_window) break; end
    end
  end

  task automatic run_scan(input int cnt, input bit rnd, input bit poke);
    @(negedge clk);
    trig_count = (CELL_W+1)'(cnt);
    rand_mode = rnd; host_lvl = 1; data_present = 1; meas_window = 0;
    if (poke) begin
      repeat (20) @(negedge clk);
      trig_count = 2;
    end
    while (!scan_done) @(negedge clk);
    repeat (3) @(negedge clk);
    meas_window = 1; data_present = 0; rand_mode = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {start_out, clock_out, sample, convert, scan_done}, 0, "strobes in reset");
    chk("R1", {mod_addr, chan_addr, cell_idx}, 0, "address in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1", {start_out, clock_out, scan_done, cell_idx}, 0, "after reset");
    // R2: each start condition withheld in turn
    host_lvl = 1; data_present = 1; meas_window = 1; repeat (5) @(negedge clk);
    meas_window = 0; data_present = 0; repeat (5) @(negedge clk);
    data_present = 1; host_lvl = 0; repeat (5) @(negedge clk);
    chk("R2", start_out, 0, "no start with host not ready");
    meas_window = 1; data_present = 0;
    run_scan(3, 0, 1);
    run_scan(DEPTH, 1, 0);
    run_scan(0, 1, 0);
    run_scan(13, 1, 0);
    chk("R9", scan_done, 0, "idle after window reopened");
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired t=%0t", $time);
    summary();
  end
endmodule